// File: doc/BRIEF.md
# Cascaded Reloadable Real-Time Clock

The block keeps long-running time as a chain of up-counters driven by a one-cycle
reference pulse, `tick_i`. The pulse is gated by a run bit. It then passes through
two prescalers, which divide by 32 and by 8 and can each be switched in or bypassed.
The prescaler output steps a 16-bit reloadable counter. Every overflow of that counter
advances a 32-bit timer built from four reloadable fields of 10, 6, 6 and 10 bits. The
16-bit counter and the 32-bit timer together give 48 bits of range.

When a counter passes its all-ones value, it restarts from its own reload value and
advances the next stage by one. Each of the five stages sets a sticky flag when it
overflows. The flags that are enabled are ORed onto one interrupt line.

Software uses a small word-addressed register port. Writes take effect at the clock
edge. Reads are combinational. The registers are cleared only by the power reset `rst_ni`.

Top module: `rtc_chain`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low. Register addresses: 0 control, 1 flags, 2 16-bit counter, 3 16-bit reload, 4 timer counter, 5 timer reload.
- R2: While control bit 0 (run) is 0, `tick_i` has no effect on any counter.
- R3: Control bit 1 switches in the divide-by-32 prescaler and bit 2 the divide-by-8 prescaler. The 16-bit counter advances once per 1, 8, 32 or 256 run ticks, depending on which prescalers are switched in. Writing control with run low restarts both prescalers.
- R4: When the 16-bit counter steps from 0xFFFF, it loads its reload value and advances timer field 0 by one.
- R5: Each timer field counts up. On a step from all-ones, a field loads its own reload value and advances the next field, and several fields may ripple in the same cycle.
- R6: In the timer counter and reload words, field 0 is bits [9:0], field 1 is bits [15:10], field 2 is bits [21:16] and field 3 is bits [31:22].
- R7: Flag bit 0 belongs to the 16-bit counter and flag bits 1 to 4 to timer fields 0 to 3. A flag is set by its stage's overflow and held until 1 is written to it. A set in the same cycle wins over the clear.
- R8: `irq_o` is high exactly when some flag is set whose enable bit, control bit 4 + source index, is 1.
- R9: A counter write is visible after the next clock and replaces any increment in that cycle. No overflow carry is produced from the written stage in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power reset |
| tick_i | input | 1 | One-cycle reference clock pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is an overflow of the high timer field, or a ripple through all five stages in one cycle. With the default reload values this needs about 2^48 ticks. The bench reaches it by setting the reload values to short periods (4, 3, 2 and 16 counts) and by preloading the 16-bit counter at 0xFFFF, so that every tick carries into the timer. The expected field values then follow from a mixed-radix split of the tick count. To reach a full ripple in a single cycle, the bench loads every counter at all-ones. To check that a write and a same-cycle tick or overflow resolve in favour of the write, the bench drives both in the same cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD  = 4;
  localparam int PCNT_W  = 16;
  localparam int DATA_W  = 32;
  localparam int NSRC    = NFIELD + 1;
  localparam int FIELD_W [NFIELD] = '{10, 6, 6, 10};

  function automatic int field_lsb(int idx);
    int s = 0;
    for (int k = 0; k < idx; k++) s += FIELD_W[k];
    return s;
  endfunction

  localparam int TIMER_W = field_lsb(NFIELD);

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_FLAG = 3'd1,
    A_PCNT = 3'd2,
    A_PREL = 3'd3,
    A_TCNT = 3'd4,
    A_TREL = 3'd5
  } reg_addr_e;

  localparam int C_RUN  = 0;
  localparam int C_P32  = 1;
  localparam int C_P8   = 2;
  localparam int C_IE   = 4;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_LOG2 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic active_i,
  output logic en_o
);
  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign en_o = active_i ? (tick_i && (&cnt_q)) : tick_i;

  // R3: a switched-in divider never emits two adjacent pulses
  a_r3_carry_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && active_i) |=> !(en_o && active_i));
endmodule

// File: rtl/rtc_stage.sv
module rtc_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] rel_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap  = &cnt_q;
  assign ovf_o = inc_i && wrap && !ld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (inc_i) cnt_q <= wrap ? rel_i : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_o == $past(ld_val_i));
  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && &cnt_o) |=> cnt_o == $past(rel_i));
  a_r5_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && !(&cnt_o)) |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rtc_chain.sv
module rtc_chain
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              run_q, p32_q, p8_q;
  logic [NSRC-1:0]   ie_q, flag_q, src_ovf, clr_mask;
  logic [PCNT_W-1:0] prel_q, pcnt;
  logic [TIMER_W-1:0] trel_q, tcnt;
  logic              tick_g, en_a, en16, ovf16;
  logic              wr_ctrl, wr_flag, wr_pcnt, wr_prel, wr_tcnt, wr_trel;
  logic [NFIELD:0]   fld_inc;

  assign wr_ctrl = wr_en_i && addr_i == A_CTRL;
  assign wr_flag = wr_en_i && addr_i == A_FLAG;
  assign wr_pcnt = wr_en_i && addr_i == A_PCNT;
  assign wr_prel = wr_en_i && addr_i == A_PREL;
  assign wr_tcnt = wr_en_i && addr_i == A_TCNT;
  assign wr_trel = wr_en_i && addr_i == A_TREL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      p32_q  <= 1'b0;
      p8_q   <= 1'b0;
      ie_q   <= '0;
      prel_q <= '0;
      trel_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wdata_i[C_RUN];
        p32_q <= wdata_i[C_P32];
        p8_q  <= wdata_i[C_P8];
        ie_q  <= wdata_i[C_IE +: NSRC];
      end
      if (wr_prel) prel_q <= wdata_i[PCNT_W-1:0];
      if (wr_trel) trel_q <= wdata_i[TIMER_W-1:0];
    end
  end

  assign tick_g = tick_i && run_q;

  rtc_prescaler #(.DIV_LOG2(5)) u_pre32 (
    .clk_i, .rst_ni, .tick_i(tick_g), .active_i(run_q && p32_q), .en_o(en_a));
  rtc_prescaler #(.DIV_LOG2(3)) u_pre8 (
    .clk_i, .rst_ni, .tick_i(en_a), .active_i(run_q && p8_q), .en_o(en16));

  rtc_stage #(.W(PCNT_W)) u_pcnt (
    .clk_i, .rst_ni, .inc_i(en16), .ld_i(wr_pcnt),
    .ld_val_i(wdata_i[PCNT_W-1:0]), .rel_i(prel_q), .cnt_o(pcnt), .ovf_o(ovf16));

  assign fld_inc[0] = ovf16;
  assign src_ovf[0] = ovf16;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    localparam int W   = FIELD_W[g];
    localparam int LSB = field_lsb(g);
    logic [W-1:0] cnt;
    rtc_stage #(.W(W)) u_fld (
      .clk_i, .rst_ni, .inc_i(fld_inc[g]), .ld_i(wr_tcnt),
      .ld_val_i(wdata_i[LSB +: W]), .rel_i(trel_q[LSB +: W]),
      .cnt_o(cnt), .ovf_o(fld_inc[g+1]));
    assign tcnt[LSB +: W] = cnt;
    assign src_ovf[g+1]   = fld_inc[g+1];
  end

  assign clr_mask = wr_flag ? wdata_i[NSRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_mask) | src_ovf;
  end

  assign irq_o = |(flag_q & ie_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[C_RUN]        = run_q;
        rdata_o[C_P32]        = p32_q;
        rdata_o[C_P8]         = p8_q;
        rdata_o[C_IE +: NSRC] = ie_q;
      end
      A_FLAG: rdata_o[NSRC-1:0]    = flag_q;
      A_PCNT: rdata_o[PCNT_W-1:0]  = pcnt;
      A_PREL: rdata_o[PCNT_W-1:0]  = prel_q;
      A_TCNT: rdata_o[TIMER_W-1:0] = tcnt;
      A_TREL: rdata_o[TIMER_W-1:0] = trel_q;
      default: rdata_o = '0;
    endcase
  end

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_mask)) == $past(flag_q & ~clr_mask)));
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_ovf) |=> ((flag_q & $past(src_ovf)) == $past(src_ovf)));
  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == '0) |-> !irq_o);
  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_pcnt) |=> $stable(pcnt));
endmodule

// File: tb/rtc_chain_bench.sv
module rtc_chain_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rtc_chain u_rtc_chain (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d, input logic t);
    wr = w; addr = a; wdata = d; tick = t;
    @(posedge clk); #5;
    wr = 1'b0; tick = 1'b0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'd0, 1'b1);
  endtask

  task automatic chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: actual %h expected %h", req, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    #1; checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq: actual %b expected %b", req, irq, exp);
    end
  endtask

  function automatic logic [31:0] pack(input int f0, input int f1, input int f2, input int f3);
    return {f3[9:0], f2[5:0], f1[5:0], f0[9:0]};
  endfunction

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0, r1, r2, r3;
    #35 rst_n = 1'b1;
    @(posedge clk); #5;

    // R1 reset state
    for (int a = 0; a < 6; a++) chk("R1", 3'(a), 32'd0);
    chk_irq("R1", 1'b0);

    // R2 no counting while run is low
    ticks(10);
    chk("R2", 3'd2, 32'd0);
    chk("R2", 3'd4, 32'd0);

    // R3 prescaler combinations
    for (int cfg = 0; cfg < 4; cfg++) begin
      int div;
      div = ((cfg & 1) ? 32 : 1) * ((cfg & 2) ? 8 : 1);
      wreg(3'd0, 32'd0);
      wreg(3'd2, 32'd0);
      wreg(3'd0, 32'(1 | (cfg << 1)));
      ticks(div * 3 + div - 1);
      chk("R3", 3'd2, 32'd3);
      ticks(1);
      chk("R3", 3'd2, 32'd4);
    end

    // R4 16-bit reload and carry into field 0
    wreg(3'd0, 32'd1);
    wreg(3'd3, 32'hFFF0);
    wreg(3'd2, 32'hFFFE);
    wreg(3'd5, 32'd0);
    wreg(3'd4, 32'd0);
    wreg(3'd1, 32'h1F);
    ticks(1);
    chk("R4", 3'd2, 32'hFFFF);
    chk("R4", 3'd4, 32'd0);
    ticks(1);
    chk("R4", 3'd2, 32'hFFF0);
    chk("R4", 3'd4, 32'd1);
    chk("R7", 3'd1, 32'h01);
    ticks(48);
    chk("R4", 3'd2, 32'hFFF0);
    chk("R4", 3'd4, 32'd4);

    // R5/R6 mixed-radix sweep with every tick carrying into the timer
    r0 = 'h3FC; r1 = 'h3D; r2 = 'h3E; r3 = 'h3F0;
    wreg(3'd3, 32'hFFFF);
    wreg(3'd2, 32'hFFFF);
    wreg(3'd5, pack(r0, r1, r2, r3));
    wreg(3'd4, pack(r0, r1, r2, r3));
    wreg(3'd1, 32'h1F);
    for (int n = 1; n <= 60; n++) begin
      int c0, c1, c2;
      ticks(1);
      c0 = n / 4; c1 = c0 / 3; c2 = c1 / 2;
      chk("R5 R6", 3'd4, pack(r0 + n % 4, r1 + c0 % 3, r2 + c1 % 2, r3 + c2));
    end
    chk("R7", 3'd1, 32'h0F);

    // R7 write-1 clear and set-over-clear
    wreg(3'd1, 32'h03);
    chk("R7", 3'd1, 32'h0C);
    cyc(1'b1, 3'd1, 32'h01, 1'b1);
    chk("R7", 3'd1, 32'h0D);

    // R8 interrupt combine
    wreg(3'd0, 32'h1 | (32'h1 << 6));
    chk_irq("R8", 1'b1);
    wreg(3'd1, 32'h04);
    chk_irq("R8", 1'b0);
    wreg(3'd0, 32'h1 | (32'h1 << 7));
    chk_irq("R8", 1'b1);

    // R9 write beats same-cycle increment and suppresses carry
    wreg(3'd1, 32'h1F);
    wreg(3'd4, 32'd0);
    cyc(1'b1, 3'd2, 32'h0042, 1'b1);
    chk("R9", 3'd2, 32'h0042);
    chk("R9", 3'd4, 32'd0);
    chk("R9", 3'd1, 32'h00);
    wreg(3'd2, 32'hFFFF);
    cyc(1'b1, 3'd4, 32'd5, 1'b1);
    chk("R9", 3'd4, 32'd5);

    // R5/R7 full ripple through every stage in one cycle
    wreg(3'd1, 32'h1F);
    wreg(3'd4, 32'hFFFF_FFFF);
    wreg(3'd2, 32'hFFFF);
    ticks(1);
    chk("R5", 3'd4, pack(r0, r1, r2, r3));
    chk("R7", 3'd1, 32'h1F);
    chk_irq("R8", 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule